// File: doc/BRIEF.md
# Memory Bus Decoder with Boot Overlay

This block sits between the CPU of a small 8-bit handheld system and its on-chip memories. Each CPU read or write on the 16-bit address bus is steered to exactly one target: a 256-byte start-up ROM, cartridge ROM space, video RAM, cartridge-side RAM, work RAM (also seen through a mirror window), sprite attribute RAM, an I/O register port, or a 128-byte fast RAM at the top of the map. The block drives that target's chip select and a local offset, and forwards the write data with a shared write enable. Read data comes back through a multiplexer that is combinational by default and can be registered through a parameter.

A start-up flag, set by reset, lays the start-up ROM over the lowest 256 bytes of cartridge space. The first access to the hand-off address 0x0100 clears the flag, and it stays clear until the next reset. The flag is brought out on a status pin. A small unused gap above the sprite RAM reads as zero and ignores writes. Writes that land in cartridge space are passed on to the cartridge port, so that an outside bank controller can act on them.

Top module: `membus_router`

## Requirements
- R1: After reset `overlay_active` is 1. While it is 1, a read of 0x0000–0x00FF asserts `boot_cs`, drives `loc_addr` = {8'h00, addr[7:0]} and returns `boot_rdata`.
- R2: A read or write of address 0x0100 while `overlay_active` is 1 clears the flag at the next clock edge. The flag then stays 0 for every later access until reset, and 0x0000–0x00FF decodes as cartridge space.
- R3: Outside the overlay, 0x0000–0x7FFF asserts `cart_cs` with `loc_addr` equal to the full address. Writes there assert `mem_we` with `mem_wdata` = `cpu_wdata`.
- R4: 0x8000–0x9FFF asserts `vram_cs` and 0xA000–0xBFFF asserts `eram_cs`, each with `loc_addr` = {3'b0, addr[12:0]}.
- R5: 0xC000–0xDFFF and its mirror 0xE000–0xFDFF both assert `wram_cs` with `loc_addr` = {3'b0, addr[12:0]}.
- R6: 0xFE00–0xFE9F asserts `oam_cs` with `loc_addr` = {8'h00, addr[7:0]}. In 0xFEA0–0xFEFF reads return 0x00, and writes assert no select and no `mem_we`.
- R7: 0xFF00–0xFF7F asserts `io_cs` and 0xFF80–0xFFFF asserts `hram_cs`, each with `loc_addr` = {9'b0, addr[6:0]}.
- R8: At most one select is high in any cycle, and none is high while neither `cpu_rd` nor `cpu_wr` is asserted.
- R9: A write to 0x0000–0x00FF while the overlay is active asserts no select and no `mem_we`.
- R10: With `RDATA_REG`=0, `cpu_rdata` is the selected region's read data in the same cycle. With `RDATA_REG`=1 it is that value one clock later, and 0 during reset.
- R11: `overlay_active` shows the start-up flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |
| loc_addr | output | 16 | Offset within the selected region |
| mem_wdata | output | DATA_W | Write data to the regions |
| mem_we | output | 1 | Write enable for the selected region |
| boot_cs | output | 1 | Start-up ROM select |
| cart_cs | output | 1 | Cartridge space select |
| vram_cs | output | 1 | Video RAM select |
| eram_cs | output | 1 | Cartridge RAM select |
| wram_cs | output | 1 | Work RAM select |
| oam_cs | output | 1 | Sprite attribute RAM select |
| io_cs | output | 1 | I/O register port select |
| hram_cs | output | 1 | Fast top RAM select |
| boot_rdata | input | DATA_W | Start-up ROM read data |
| cart_rdata | input | DATA_W | Cartridge read data |
| vram_rdata | input | DATA_W | Video RAM read data |
| eram_rdata | input | DATA_W | Cartridge RAM read data |
| wram_rdata | input | DATA_W | Work RAM read data |
| oam_rdata | input | DATA_W | Sprite RAM read data |
| io_rdata | input | DATA_W | I/O port read data |
| hram_rdata | input | DATA_W | Fast RAM read data |
| overlay_active | output | 1 | Start-up overlay flag |

## Verification
The hardest behaviour to reach from the ports is the overlay's lifetime. It clears only on one address and can come back only through reset. The stimulus first covers the low 256 bytes with the flag set, including a dropped write. It then touches 0x0100 by reading and checks that low addresses now reach cartridge space, and that a second touch of 0x0100 changes nothing. Finally it resets mid-run and clears the flag with a write this time. A second instance with registered read data runs beside the first, and its output is checked against the value expected one access earlier.

// File: rtl/membus_pkg.sv
// Shared definitions for the memory bus router.
// Assumes a 16-bit CPU address space; region codes double as mux indices.
package membus_pkg;

    localparam int ADDR_W = 16;
    localparam int LOC_W  = 16;
    localparam int N_SRC  = 8;

    // Address whose access ends the start-up overlay.
    localparam logic [ADDR_W-1:0] HANDOFF_ADDR = 16'h0100;
    // First unused byte above the sprite attribute RAM (low byte of the FExx page).
    localparam logic [7:0] OAM_LIMIT = 8'hA0;

    // Codes 0..N_SRC-1 index the read data sources; RG_HOLE has no source.
    typedef enum logic [3:0] {
        RG_BOOT = 4'd0,
        RG_CART = 4'd1,
        RG_VRAM = 4'd2,
        RG_ERAM = 4'd3,
        RG_WRAM = 4'd4,
        RG_OAM  = 4'd5,
        RG_IO   = 4'd6,
        RG_HRAM = 4'd7,
        RG_HOLE = 4'd8
    } region_e;

endpackage

// File: rtl/membus_region_decode.sv
// Address decoder: maps a CPU address to a region code and a local offset.
// Purely combinational; assumes the overlay flag comes from a register.
module membus_region_decode
    import membus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              overlay,
    output region_e           region,
    output logic [LOC_W-1:0]  offset
);

    // Picks the region by the top three address bits, then refines the top 8 KiB.
    always_comb begin
        region = RG_CART;
        offset = addr;
        case (addr[15:13])
            3'd0, 3'd1, 3'd2, 3'd3: begin
                if (overlay && (addr[15:8] == 8'h00)) begin
                    region = RG_BOOT;
                    offset = {8'h00, addr[7:0]};
                end
            end
            3'd4: begin
                region = RG_VRAM;
                offset = {3'b000, addr[12:0]};
            end
            3'd5: begin
                region = RG_ERAM;
                offset = {3'b000, addr[12:0]};
            end
            3'd6: begin
                region = RG_WRAM;
                offset = {3'b000, addr[12:0]};
            end
            default: begin
                if (addr[12:9] != 4'hF) begin
                    region = RG_WRAM;
                    offset = {3'b000, addr[12:0]};
                end else if (!addr[8]) begin
                    if (addr[7:0] < OAM_LIMIT) begin
                        region = RG_OAM;
                        offset = {8'h00, addr[7:0]};
                    end else begin
                        region = RG_HOLE;
                        offset = '0;
                    end
                end else if (!addr[7]) begin
                    region = RG_IO;
                    offset = {9'b0, addr[6:0]};
                end else begin
                    region = RG_HRAM;
                    offset = {9'b0, addr[6:0]};
                end
            end
        endcase
    end

endmodule

// File: rtl/membus_boot_overlay.sv
// Start-up overlay flag: set by reset, cleared for good by the first
// access to the hand-off address. Assumes access is a qualified strobe.
module membus_boot_overlay
    import membus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic [ADDR_W-1:0] addr,
    output logic              active
);

    logic active_q;

    // Holds the flag; only a hand-off access may clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
        end else if (active_q && access && (addr == HANDOFF_ADDR)) begin
            active_q <= 1'b0;
        end
    end

    assign active = active_q;

    // R2: a hand-off access ends the overlay at the next edge.
    assert_overlay_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && access && (addr == HANDOFF_ADDR)) |=> !active_q);

    // R2: once cleared, the flag never returns without reset.
    assert_overlay_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |=> !active_q);

    // R2: the flag does not drop without a hand-off access.
    assert_overlay_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !(access && (addr == HANDOFF_ADDR))) |=> active_q);

endmodule

// File: rtl/membus_rdata_mux.sv
// Read data selector: picks the source named by the region code, zero for
// the unused gap. A parameter chooses a combinational or a registered output.
module membus_rdata_mux
    import membus_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RDATA_REG = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  region_e                       region,
    input  logic [N_SRC-1:0][DATA_W-1:0]  src,
    output logic [DATA_W-1:0]             rdata
);

    logic [DATA_W-1:0] sel_data;

    // Chooses the source; the gap region has none and yields zero.
    always_comb begin
        if (region == RG_HOLE) begin
            sel_data = '0;
        end else begin
            sel_data = src[region[2:0]];
        end
    end

    if (RDATA_REG != 0) begin : g_reg
        logic [DATA_W-1:0] rdata_q;

        // Registers the selected data for one cycle of latency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_q <= '0;
            end else begin
                rdata_q <= sel_data;
            end
        end

        assign rdata = rdata_q;

        // R6: a gap access returns zero one cycle later.
        assert_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (region == RG_HOLE) |=> (rdata == '0));
    end else begin : g_comb
        assign rdata = sel_data;

        // R6: a gap access returns zero in the same cycle.
        assert_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (region == RG_HOLE) |-> (rdata == '0));
    end

endmodule

// File: rtl/membus_router.sv
// Memory bus router top: decodes CPU accesses into one-hot region selects,
// local offsets and a shared write enable, and returns the read data.
// Assumes cpu_rd and cpu_wr are never high together.
module membus_router
    import membus_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RDATA_REG = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [15:0]       loc_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              boot_cs,
    output logic              cart_cs,
    output logic              vram_cs,
    output logic              eram_cs,
    output logic              wram_cs,
    output logic              oam_cs,
    output logic              io_cs,
    output logic              hram_cs,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] cart_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic [DATA_W-1:0] eram_rdata,
    input  logic [DATA_W-1:0] wram_rdata,
    input  logic [DATA_W-1:0] oam_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] hram_rdata,
    output logic              overlay_active
);

    region_e                      region;
    logic [LOC_W-1:0]             offset;
    logic                         access;
    logic [N_SRC-1:0]             cs_vec;
    logic [N_SRC-1:0][DATA_W-1:0] src;

    assign access = cpu_rd | cpu_wr;

    membus_boot_overlay u_overlay (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (access),
        .addr   (cpu_addr),
        .active (overlay_active)
    );

    membus_region_decode u_decode (
        .addr    (cpu_addr),
        .overlay (overlay_active),
        .region  (region),
        .offset  (offset)
    );

    // One select per source; the start-up ROM takes reads only.
    for (genvar i = 0; i < N_SRC; i++) begin : g_sel
        localparam bit WR_OK = (i != int'(RG_BOOT));
        assign cs_vec[i] = (region == region_e'(i)) && (cpu_rd || (cpu_wr && WR_OK));
    end

    assign boot_cs = cs_vec[RG_BOOT];
    assign cart_cs = cs_vec[RG_CART];
    assign vram_cs = cs_vec[RG_VRAM];
    assign eram_cs = cs_vec[RG_ERAM];
    assign wram_cs = cs_vec[RG_WRAM];
    assign oam_cs  = cs_vec[RG_OAM];
    assign io_cs   = cs_vec[RG_IO];
    assign hram_cs = cs_vec[RG_HRAM];

    assign loc_addr  = offset;
    assign mem_wdata = cpu_wdata;
    assign mem_we    = cpu_wr && (cs_vec != '0);

    assign src = {hram_rdata, io_rdata, oam_rdata, wram_rdata,
                  eram_rdata, vram_rdata, cart_rdata, boot_rdata};

    membus_rdata_mux #(
        .DATA_W    (DATA_W),
        .RDATA_REG (RDATA_REG)
    ) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .region (region),
        .src    (src),
        .rdata  (cpu_rdata)
    );

    // R8: the CPU never raises both strobes at once.
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_wr));

    // R8: never more than one region selected.
    assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_cs, cart_cs, vram_cs, eram_cs, wram_cs, oam_cs, io_cs, hram_cs}));

    // R8: no select without a strobe.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !access |-> ({boot_cs, cart_cs, vram_cs, eram_cs, wram_cs, oam_cs, io_cs, hram_cs} == '0));

    // R6: the gap above sprite RAM selects nothing and writes nowhere.
    assert_gap_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (cpu_addr >= 16'hFEA0) && (cpu_addr <= 16'hFEFF))
        |-> (({boot_cs, cart_cs, vram_cs, eram_cs, wram_cs, oam_cs, io_cs, hram_cs} == '0) && !mem_we));

    // R5: the mirror window reaches work RAM at the same offset.
    assert_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (cpu_addr >= 16'hE000) && (cpu_addr < 16'hFE00))
        |-> (wram_cs && (loc_addr == {3'b000, cpu_addr[12:0]})));

    // R9: writes under the overlay are dropped.
    assert_boot_write_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && overlay_active && (cpu_addr < 16'h0100)) |-> (!mem_we && !boot_cs && !cart_cs));

    // R1: the overlay routes low reads to the start-up ROM.
    assert_boot_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && overlay_active && (cpu_addr < 16'h0100)) |-> (boot_cs && (loc_addr == cpu_addr)));

endmodule

// File: tb/membus_router_bench.sv
// Scoreboard bench: the driver pushes expected results, the monitor checks them.
module membus_router_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;

    logic [DW-1:0] cpu_rdata, mem_wdata;
    logic [15:0]   loc_addr;
    logic          mem_we, overlay_active;
    logic          boot_cs, cart_cs, vram_cs, eram_cs, wram_cs, oam_cs, io_cs, hram_cs;

    logic [DW-1:0] q_rdata, q_mem_wdata;
    logic [15:0]   q_loc_addr;
    logic          q_mem_we, q_overlay;
    logic [7:0]    q_cs;

    localparam logic [DW-1:0] D_BOOT = 8'h11, D_CART = 8'h22, D_VRAM = 8'h33, D_ERAM = 8'h44,
                              D_WRAM = 8'h55, D_OAM = 8'h66, D_IO = 8'h77, D_HRAM = 8'h88;

    always #5 clk = ~clk;

    membus_router u_membus_router (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .loc_addr(loc_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .boot_cs(boot_cs), .cart_cs(cart_cs), .vram_cs(vram_cs), .eram_cs(eram_cs),
        .wram_cs(wram_cs), .oam_cs(oam_cs), .io_cs(io_cs), .hram_cs(hram_cs),
        .boot_rdata(D_BOOT), .cart_rdata(D_CART), .vram_rdata(D_VRAM), .eram_rdata(D_ERAM),
        .wram_rdata(D_WRAM), .oam_rdata(D_OAM), .io_rdata(D_IO), .hram_rdata(D_HRAM),
        .overlay_active(overlay_active)
    );

    membus_router #(.RDATA_REG(1)) u_membus_router_q (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(q_rdata), .loc_addr(q_loc_addr),
        .mem_wdata(q_mem_wdata), .mem_we(q_mem_we),
        .boot_cs(q_cs[7]), .cart_cs(q_cs[6]), .vram_cs(q_cs[5]), .eram_cs(q_cs[4]),
        .wram_cs(q_cs[3]), .oam_cs(q_cs[2]), .io_cs(q_cs[1]), .hram_cs(q_cs[0]),
        .boot_rdata(D_BOOT), .cart_rdata(D_CART), .vram_rdata(D_VRAM), .eram_rdata(D_ERAM),
        .wram_rdata(D_WRAM), .oam_rdata(D_OAM), .io_rdata(D_IO), .hram_rdata(D_HRAM),
        .overlay_active(q_overlay)
    );

    wire [7:0] cs_vec = {boot_cs, cart_cs, vram_cs, eram_cs, wram_cs, oam_cs, io_cs, hram_cs};

    typedef struct packed {
        logic [15:0]   loc;
        logic [7:0]    mask;
        logic [DW-1:0] rdx;
        logic [DW-1:0] wd;
        logic          rd;
        logic          we;
        logic          ov;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    event  ev_sample;

    int            n_tests = 0;
    int            n_fail = 0;
    bit            ov_model = 1'b1;
    bit            prev_valid = 1'b0;
    logic [DW-1:0] prev_rdx = '0;

    // Counts one check and reports it when it fails.
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected decode written from the requirements (mask bit 7 = boot ... bit 0 = fast RAM).
    function automatic exp_t model(input logic [15:0] a, input bit rd, input bit wr,
                                   input logic [DW-1:0] d, input bit ov);
        exp_t e;
        e.loc = a; e.mask = 8'h40; e.rdx = D_CART; e.wd = d; e.rd = rd; e.ov = ov;
        if (a < 16'h8000) begin
            if (ov && a < 16'h0100) begin e.mask = 8'h80; e.loc = {8'h00, a[7:0]}; e.rdx = D_BOOT; end
        end else if (a < 16'hA000) begin e.mask = 8'h20; e.loc = {3'b0, a[12:0]}; e.rdx = D_VRAM; end
        else if (a < 16'hC000) begin e.mask = 8'h10; e.loc = {3'b0, a[12:0]}; e.rdx = D_ERAM; end
        else if (a < 16'hFE00) begin e.mask = 8'h08; e.loc = {3'b0, a[12:0]}; e.rdx = D_WRAM; end
        else if (a < 16'hFEA0) begin e.mask = 8'h04; e.loc = {8'h00, a[7:0]}; e.rdx = D_OAM; end
        else if (a < 16'hFF00) begin e.mask = 8'h00; e.loc = '0; e.rdx = '0; end
        else if (a < 16'hFF80) begin e.mask = 8'h02; e.loc = {9'b0, a[6:0]}; e.rdx = D_IO; end
        else begin e.mask = 8'h01; e.loc = {9'b0, a[6:0]}; e.rdx = D_HRAM; end
        if (!rd && !wr) e.mask = 8'h00;
        if (wr && e.mask == 8'h80) e.mask = 8'h00;
        e.we = wr && (e.mask != 8'h00);
        return e;
    endfunction

    // Driver: applies one bus cycle and queues what the monitor must see.
    task automatic drive(input logic [15:0] a, input bit rd, input bit wr,
                         input logic [DW-1:0] d, input string tg);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        expq.push_back(model(a, rd, wr, d, ov_model));
        tagq.push_back(tg);
        #2;
        -> ev_sample;
        if ((rd || wr) && a == 16'h0100) ov_model = 1'b0;
    endtask

    // Applies reset and checks the reset state.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0;
        repeat (3) @(negedge clk);
        chk(overlay_active == 1'b1, "R1 overlay set in reset", 32'(overlay_active), 1);
        chk(q_rdata == '0, "R10 registered data zero in reset", 32'(q_rdata), 0);
        rst_n = 1'b1;
        ov_model = 1'b1;
        prev_valid = 1'b0;
    endtask

    // Monitor: pops each expected item and compares it with the ports.
    initial begin
        forever begin
            exp_t  it;
            string tg;
            @(ev_sample);
            it = expq.pop_front();
            tg = tagq.pop_front();
            chk(overlay_active == it.ov, {tg, " R11 overlay flag"}, 32'(overlay_active), 32'(it.ov));
            chk(cs_vec == it.mask, {tg, " select"}, 32'(cs_vec), 32'(it.mask));
            if (it.mask != 8'h00)
                chk(loc_addr == it.loc, {tg, " offset"}, 32'(loc_addr), 32'(it.loc));
            chk(mem_we == it.we, {tg, " write enable"}, 32'(mem_we), 32'(it.we));
            if (it.we)
                chk(mem_wdata == it.wd, {tg, " write data"}, 32'(mem_wdata), 32'(it.wd));
            if (it.rd)
                chk(cpu_rdata == it.rdx, {tg, " R10 read data"}, 32'(cpu_rdata), 32'(it.rdx));
            if (prev_valid)
                chk(q_rdata == prev_rdx, {tg, " R10 registered read data"}, 32'(q_rdata), 32'(prev_rdx));
            prev_rdx = it.rdx;
            prev_valid = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        do_reset();
        drive(16'h0000, 0, 0, 8'h00, "R1 idle after reset");
        drive(16'h0000, 1, 0, 8'h00, "R1 boot read low");
        drive(16'h00FF, 1, 0, 8'h00, "R1 boot read top");
        drive(16'h0010, 0, 1, 8'hA5, "R9 boot write dropped");
        drive(16'h0150, 1, 0, 8'h00, "R3 cart above overlay");
        drive(16'h7FFF, 1, 0, 8'h00, "R3 cart top");
        drive(16'h2000, 0, 1, 8'h05, "R3 bank control write");
        drive(16'h0100, 1, 0, 8'h00, "R2 handoff read");
        drive(16'h0000, 1, 0, 8'h00, "R2 low range now cart");
        drive(16'h0080, 0, 1, 8'h3C, "R2 low write now cart");
        drive(16'h0100, 1, 0, 8'h00, "R2 second handoff");
        drive(16'h0001, 1, 0, 8'h00, "R2 overlay stays clear");
        drive(16'h8000, 1, 0, 8'h00, "R4 vram low");
        drive(16'h9FFF, 0, 1, 8'h9A, "R4 vram top write");
        drive(16'hA123, 1, 0, 8'h00, "R4 eram read");
        drive(16'hBFFF, 0, 1, 8'hB1, "R4 eram top write");
        drive(16'hC000, 1, 0, 8'h00, "R5 wram low");
        drive(16'hDFFF, 0, 1, 8'hD7, "R5 wram top write");
        drive(16'hE000, 1, 0, 8'h00, "R5 mirror low");
        drive(16'hFDFF, 1, 0, 8'h00, "R5 mirror top");
        drive(16'hF123, 0, 1, 8'hF1, "R5 mirror write");
        drive(16'hFE00, 1, 0, 8'h00, "R6 sprite ram low");
        drive(16'hFE9F, 0, 1, 8'h9F, "R6 sprite ram top write");
        drive(16'hFEA0, 1, 0, 8'h00, "R6 gap read zero");
        drive(16'hFEFF, 0, 1, 8'hEE, "R6 gap write ignored");
        drive(16'hFF00, 1, 0, 8'h00, "R7 io low");
        drive(16'hFF7F, 0, 1, 8'h7F, "R7 io top write");
        drive(16'hFF80, 1, 0, 8'h00, "R7 hram low");
        drive(16'hFFFF, 0, 1, 8'hFF, "R7 hram top write");
        drive(16'h8100, 0, 0, 8'h00, "R8 idle no select");
        do_reset();
        drive(16'h0042, 1, 0, 8'h00, "R1 overlay back after reset");
        drive(16'h0100, 0, 1, 8'h12, "R2 handoff by write");
        drive(16'h0042, 1, 0, 8'h00, "R2 cart after write handoff");
        @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule